// File: doc/BRIEF.md
# Multiplexed Ring-Oscillator Frequency Counter

This block counts rising edges from one of seven free-running oscillator inputs. The count runs during a measurement window that a level input opens and closes. A one-hot decoder and an eight-way selector choose the oscillator. The selected signal passes through a two-flop synchronizer into the reference clock domain. A rising-edge detector then feeds a wide event counter.

When the window opens, the count and a sticky wrap flag are cleared. When the window closes, the count is frozen. The selector code is loaded through a serial scan register, and the same register reads out the result. A capture strobe snapshots the count, the wrap flag and the current selector code into the register. A shift strobe moves the frame out, most significant bit first. An update strobe copies the low field of the shifted-in frame into the selector register.

The measured frequency is the count divided by the window length in reference clock cycles. The synchronizer limits the usable oscillator rate to below half the reference clock.

Top module: `ro_freq_meter`

## Requirements
- R1: Selector codes 0 to 6 route oscillator input bit of that index to the counter; edges on any other oscillator input do not change the count.
- R2: Selector code 7 routes a constant zero, so the count stays at zero over a whole window whatever the oscillator inputs do.
- R3: While the window is open, each rising edge of the selected oscillator increments the count by exactly one. The counter is CNT_W bits wide, 28 by default.
- R4: A rising edge of the window input clears both the count and the wrap flag, so a fresh window starts from zero.
- R5: A falling edge of the window input freezes the count, and oscillator edges after that have no effect.
- R6: When the count increments from all ones, it wraps to zero and the wrap flag sets. The flag stays set until the next window start.
- R7: A capture strobe loads the frame {count, wrap flag, 3-bit selector code}. Shift strobes then present it on the scan output, most significant bit first; each shift takes the scan input into the frame LSB.
- R8: An update strobe loads the selector code from the 3 least significant bits of the shifted-in frame. Shifting without an update leaves the selector code unchanged.
- R9: After reset the count, the wrap flag and the selector code are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_i | input | NUM_OSC | Oscillator inputs, asynchronous |
| run_i | input | 1 | Measurement window, high opens it, asynchronous |
| scan_capture_i | input | 1 | Snapshot the count, flag and selector code into the scan register |
| scan_shift_i | input | 1 | Shift the scan register one place toward the MSB |
| scan_update_i | input | 1 | Load the selector code from the scan register LSBs |
| scan_in_i | input | 1 | Serial scan input |
| scan_out_o | output | 1 | Serial scan output, the scan register MSB |

## Verification
The bench uses edge trains of different lengths on the selected input, so an off-by-one or a lost edge gives a wrong count. It also pulses unselected oscillators during a window, which separates the selector from a plain OR of the inputs. Code 7 is tried with every oscillator toggling, to show the unused selector slot is really dead. Edges after the window closes, and a train long enough to wrap a narrowed counter, check that the count freezes and that the flag is sticky. A second window after each of these checks that both are cleared. A shift with no update tests whether the selector register is held apart from the scan path.

// File: rtl/ro_freq_meter.sv
module ro_freq_meter #(
  parameter int NUM_OSC = 7,
  parameter int SEL_W   = 3,
  parameter int CNT_W   = 28
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_OSC-1:0] osc_i,
  input  logic               run_i,
  input  logic               scan_capture_i,
  input  logic               scan_shift_i,
  input  logic               scan_update_i,
  input  logic               scan_in_i,
  output logic               scan_out_o
);
  localparam int SLOTS   = 1 << SEL_W;
  localparam int FRAME_W = CNT_W + 1 + SEL_W;

  logic [SEL_W-1:0]   cfg_q;
  logic [SLOTS-1:0]   dec;
  logic               osc_sel;
  logic [2:0]         osc_p;
  logic [2:0]         run_p;
  logic               edge_hit, run_s, run_d, start;
  logic [CNT_W-1:0]   cnt_q;
  logic               ovf_q;
  logic [CNT_W:0]     cnt_inc;
  logic [FRAME_W-1:0] sreg;

  genvar g;
  generate
    for (g = 0; g < SLOTS; g++) begin : g_dec
      assign dec[g] = (cfg_q == SEL_W'(g));
    end
    if (NUM_OSC < SLOTS) begin : g_mux_part
      assign osc_sel = |(dec[NUM_OSC-1:0] & osc_i);
    end else begin : g_mux_full
      assign osc_sel = |(dec & osc_i[SLOTS-1:0]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      osc_p <= '0;
      run_p <= '0;
    end else begin
      osc_p <= {osc_p[1:0], osc_sel};
      run_p <= {run_p[1:0], run_i};
    end

  assign edge_hit = osc_p[1] & ~osc_p[2];
  assign run_s    = run_p[1];
  assign run_d    = run_p[2];
  assign start    = run_s & ~run_d;
  assign cnt_inc  = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (start) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (run_s && edge_hit) begin
      cnt_q <= cnt_inc[CNT_W-1:0];
      if (cnt_inc[CNT_W]) ovf_q <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              sreg <= '0;
    else if (scan_capture_i) sreg <= {cnt_q, ovf_q, cfg_q};
    else if (scan_shift_i)   sreg <= {sreg[FRAME_W-2:0], scan_in_i};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)             cfg_q <= '0;
    else if (scan_update_i) cfg_q <= sreg[SEL_W-1:0];

  assign scan_out_o = sreg[FRAME_W-1];
endmodule

module ro_freq_meter_chk #(
  parameter int NUM_OSC = 7,
  parameter int SEL_W   = 3,
  parameter int CNT_W   = 28
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_s,
  input logic             run_d,
  input logic [CNT_W-1:0] cnt,
  input logic             ovf,
  input logic [SEL_W-1:0] cfg,
  input logic             shift,
  input logic             capture,
  input logic             scan_in,
  input logic             sreg_lsb
);
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_s && !run_d) |=> (cnt == '0 && !ovf)); // R4
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !run_s |=> $stable(cnt)); // R5
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_s && run_d) |=> (cnt == $past(cnt) || cnt == CNT_W'($past(cnt) + 1'b1))); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !(run_s && !run_d)) |=> ovf); // R6
  AST_DEAD_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cfg) >= NUM_OSC && int'($past(cfg)) >= NUM_OSC && int'($past(cfg, 2)) >= NUM_OSC
     && int'($past(cfg, 3)) >= NUM_OSC && !(run_s && !run_d)) |=> $stable(cnt)); // R2
  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !capture) |=> (sreg_lsb == $past(scan_in))); // R7
endmodule

bind ro_freq_meter ro_freq_meter_chk #(.NUM_OSC(NUM_OSC), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_s(run_s), .run_d(run_d), .cnt(cnt_q), .ovf(ovf_q),
  .cfg(cfg_q), .shift(scan_shift_i), .capture(scan_capture_i), .scan_in(scan_in_i),
  .sreg_lsb(sreg[0])
);

// File: tb/ro_freq_meter_tb.sv
module ro_freq_meter_tb;
  localparam int PERIOD = 10;
  localparam int NOSC   = 7;
  localparam int SW     = 3;
  localparam int CW     = 8;
  localparam int FW     = CW + 1 + SW;

  logic clk = 0, rst_n = 0;
  logic [NOSC-1:0] osc = '0;
  logic run = 0, cap = 0, sh = 0, upd = 0, sin = 0;
  logic sout;
  int total = 0, bad = 0;

  always #(PERIOD/2) clk = ~clk;

  ro_freq_meter #(.NUM_OSC(NOSC), .SEL_W(SW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .osc_i(osc), .run_i(run),
    .scan_capture_i(cap), .scan_shift_i(sh), .scan_update_i(upd),
    .scan_in_i(sin), .scan_out_o(sout)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic scan_xfer(input logic [FW-1:0] din, input bit do_upd, output logic [FW-1:0] dout);
    @(negedge clk) cap = 1;
    @(negedge clk) cap = 0;
    for (int k = 0; k < FW; k++) begin
      dout[FW-1-k] = sout;
      sin = din[FW-1-k];
      sh  = 1;
      @(negedge clk);
    end
    sh = 0;
    if (do_upd) begin
      upd = 1;
      @(negedge clk) upd = 0;
    end
  endtask

  task automatic set_sel(input int code);
    logic [FW-1:0] d;
    scan_xfer(FW'(code), 1'b1, d);
  endtask

  task automatic read_out(output int c, output int o, output int s);
    logic [FW-1:0] d;
    scan_xfer('0, 1'b0, d);
    c = int'(d[FW-1:SW+1]);
    o = int'(d[SW]);
    s = int'(d[SW-1:0]);
  endtask

  task automatic pulses(input int idx, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) osc[idx] = 1;
      repeat (3) @(negedge clk);
      osc[idx] = 0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic window(input bit on);
    @(negedge clk) run = on;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset;
    int c, o, s;
    read_out(c, o, s);
    chk("R9 count", c, 0);
    chk("R9 flag", o, 0);
    chk("R9 select", s, 0);
  endtask

  task automatic t_select;
    int c, o, s;
    set_sel(2);
    window(1);
    pulses(5, 5);
    pulses(2, 10);
    pulses(0, 3);
    window(0);
    read_out(c, o, s);
    chk("R1 R3 count on osc2", c, 10);
    chk("R7 flag field", o, 0);
    chk("R7 select field", s, 2);
  endtask

  task automatic t_freeze;
    int c, o, s;
    set_sel(6);
    window(1);
    pulses(6, 3);
    window(0);
    pulses(6, 4);
    read_out(c, o, s);
    chk("R5 frozen count", c, 3);
    chk("R1 select field", s, 6);
  endtask

  task automatic t_restart;
    int c, o, s;
    window(1);
    window(0);
    read_out(c, o, s);
    chk("R4 cleared count", c, 0);
  endtask

  task automatic t_dead_slot;
    int c, o, s;
    set_sel(7);
    window(1);
    for (int i = 0; i < NOSC; i++) pulses(i, 3);
    window(0);
    read_out(c, o, s);
    chk("R2 dead slot count", c, 0);
    chk("R2 select field", s, 7);
  endtask

  task automatic t_wrap;
    int c, o, s;
    set_sel(0);
    window(1);
    pulses(0, (1 << CW) + 2);
    window(0);
    read_out(c, o, s);
    chk("R6 wrapped count", c, 2);
    chk("R6 flag set", o, 1);
    read_out(c, o, s);
    chk("R6 flag held", o, 1);
    window(1);
    window(0);
    read_out(c, o, s);
    chk("R4 flag cleared", o, 0);
    chk("R4 count cleared", c, 0);
  endtask

  task automatic t_no_update;
    int c, o, s;
    logic [FW-1:0] d;
    set_sel(4);
    scan_xfer(FW'(3), 1'b0, d);
    read_out(c, o, s);
    chk("R8 select held without update", s, 4);
    window(1);
    pulses(3, 2);
    pulses(4, 5);
    window(0);
    read_out(c, o, s);
    chk("R8 counts held select", c, 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_select();
    t_freeze();
    t_restart();
    t_dead_slot();
    t_wrap();
    t_no_update();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule